// File: doc/BRIEF.md
# MAC Interrupt and Soft-Reset Controller

This block sits beside the transmit and receive engines of an Ethernet MAC. It collects single-cycle cause pulses from both engines into one 32-bit status word, masks them with an enable word, and drives two interrupt lines: one for transmit causes (upper half of the status word) and one for receive causes (lower half). Software clears causes by writing ones to the status word.

The block also holds the MAC command word, whose run bits go straight to the engines, and a small set of configuration registers with fixed reset values. Writing the soft-reset bit of the command word returns every register to its reset value. The bit then stays active for a fixed number of cycles. During that time every read returns zero and all writes and cause pulses are ignored. The register port is a plain word-indexed write strobe with a combinational read.

Top module: `mac_irq_rst_ctrl`

## Requirements
- R1: After the reset input, and again when a soft reset finishes, the registers read as follows:
  - transmit list start and receive list start: 0xFFFFFFFC
  - FIFO threshold: 0x00000101
  - receive maximum length: 0x00000800
  - missed-packet count: 0x00007FFF
  - MII data address: 0x00900000
  - all other registers: 0
  - `irq_tx` and `irq_rx`: low
- R2: A pulse on `cause_pulse` sets only those status bits that are defined causes.
  - Transmit causes are bits 24, 23, 18 and 16.
  - Receive causes are bits 11, 10, 9, 8, 4, 3 and 0.
  - All other bits are ignored, so the mask of all causes is 0x01850F19.
- R3: Writing the status word clears exactly the bits written as one. Zero bits leave the status unchanged, so writing 0xFFFF0000 clears only transmit causes.
- R4: A cause pulse that arrives in the same cycle as a status write clearing that bit leaves the bit set.
- R5: `irq_tx` is the OR of status bits 31..16 ANDed with the enable word. `irq_rx` is the same OR over bits 15..0.
- R6: The enable word stores only bits 18, 16, 4 and 0. Other enable bits read 0, and enabling an undefined position has no effect.
- R7: Writing a command word with bit 24 set starts a soft reset.
  - `srst_busy` is high for exactly SRST_CYCLES cycles after that write edge.
  - Every read returns 0 while it is high.
  - Afterwards bit 24 reads 0 and R1 holds.
- R8: While `srst_busy` is high, register writes and cause pulses are ignored.
- R9: The command word stores bits 8, 1 and 0, which drive `tx_en`, `long_frame_ok` and `rx_en`. A soft reset clears all three.
- R10: The register word indices are:
  - 0: command
  - 1: enable
  - 2: status
  - 3: transmit list start
  - 4: receive list start
  - 5: FIFO threshold
  - 6: receive maximum length
  - 7: missed-packet count (read-only)
  - 8: MII data address

  Other indices read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cause_pulse | input | 32 | Single-cycle cause pulses from the engines |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| tx_en | output | 1 | Transmit run (command bit 8) |
| rx_en | output | 1 | Receive run (command bit 0) |
| long_frame_ok | output | 1 | Accept long frames (command bit 1) |
| srst_busy | output | 1 | Soft reset in progress |

## Verification
Two functions can fall in the same cycle: a cause pulse from an engine and a software write that clears that cause. The bench provokes this by driving a status write with ones in bits 4 and 0 in the same cycle as a pulse on bit 4, with bit 0 already set. The expected result is that bit 4 survives and bit 0 is cleared. Writes and pulses that land inside the soft-reset window are a second case. They are judged by reading the affected registers once the window ends and finding only reset values.

// File: rtl/mac_irq_rst_ctrl.sv
module mac_irq_rst_ctrl #(
  parameter int AW          = 4,
  parameter int SRST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   cause_pulse,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          tx_en,
  output logic          rx_en,
  output logic          long_frame_ok,
  output logic          srst_busy
);
  localparam int CW = $clog2(SRST_CYCLES + 1);

  localparam logic [AW-1:0] A_CMD   = AW'(0);
  localparam logic [AW-1:0] A_IEN   = AW'(1);
  localparam logic [AW-1:0] A_STAT  = AW'(2);
  localparam logic [AW-1:0] A_TXL   = AW'(3);
  localparam logic [AW-1:0] A_RXL   = AW'(4);
  localparam logic [AW-1:0] A_FTH   = AW'(5);
  localparam logic [AW-1:0] A_RXMAX = AW'(6);
  localparam logic [AW-1:0] A_MISS  = AW'(7);
  localparam logic [AW-1:0] A_MDA   = AW'(8);

  localparam logic [31:0] TX_M   = 32'h0185_0000;
  localparam logic [31:0] RX_M   = 32'h0000_0F19;
  localparam logic [31:0] ST_M   = TX_M | RX_M;
  localparam logic [31:0] EN_M   = 32'h0005_0011;
  localparam logic [31:0] CMD_M  = 32'h0000_0103;
  localparam int          SRST_B = 24;

  localparam logic [31:0] R_LIST  = 32'hFFFF_FFFC;
  localparam logic [31:0] R_FTH   = 32'h0000_0101;
  localparam logic [31:0] R_RXMAX = 32'h0000_0800;
  localparam logic [31:0] R_MISS  = 32'h0000_7FFF;
  localparam logic [31:0] R_MDA   = 32'h0090_0000;

  logic [31:0]   cmd_q, ien_q, stat_q, txl_q, rxl_q, fth_q, rxmax_q, mda_q;
  logic [CW-1:0] cnt_q;
  logic          busy, srst_go, clr;
  logic [31:0]   stat_wclr;

  assign busy      = cnt_q != '0;
  assign srst_go   = reg_we && !busy && reg_addr == A_CMD && reg_wdata[SRST_B];
  assign clr       = srst_go || busy;
  assign stat_wclr = (reg_we && reg_addr == A_STAT) ? reg_wdata : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (srst_go) cnt_q <= CW'(SRST_CYCLES);
    else if (busy) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; ien_q <= '0; stat_q <= '0;
      txl_q <= R_LIST; rxl_q <= R_LIST; fth_q <= R_FTH;
      rxmax_q <= R_RXMAX; mda_q <= R_MDA;
    end else if (clr) begin
      cmd_q <= '0; ien_q <= '0; stat_q <= '0;
      txl_q <= R_LIST; rxl_q <= R_LIST; fth_q <= R_FTH;
      rxmax_q <= R_RXMAX; mda_q <= R_MDA;
    end else begin
      stat_q <= (stat_q & ~stat_wclr) | (cause_pulse & ST_M);
      if (reg_we) begin
        case (reg_addr)
          A_CMD:   cmd_q   <= reg_wdata & CMD_M;
          A_IEN:   ien_q   <= reg_wdata & EN_M;
          A_TXL:   txl_q   <= reg_wdata;
          A_RXL:   rxl_q   <= reg_wdata;
          A_FTH:   fth_q   <= reg_wdata;
          A_RXMAX: rxmax_q <= reg_wdata;
          A_MDA:   mda_q   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!busy) begin
      case (reg_addr)
        A_CMD:   reg_rdata = cmd_q;
        A_IEN:   reg_rdata = ien_q;
        A_STAT:  reg_rdata = stat_q;
        A_TXL:   reg_rdata = txl_q;
        A_RXL:   reg_rdata = rxl_q;
        A_FTH:   reg_rdata = fth_q;
        A_RXMAX: reg_rdata = rxmax_q;
        A_MISS:  reg_rdata = R_MISS;
        A_MDA:   reg_rdata = mda_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq_tx        = |(stat_q[31:16] & ien_q[31:16]);
  assign irq_rx        = |(stat_q[15:0] & ien_q[15:0]);
  assign tx_en         = cmd_q[8];
  assign long_frame_ok = cmd_q[1];
  assign rx_en         = cmd_q[0];
  assign srst_busy     = busy;

  a_r7_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_busy) |-> $past(reg_we && reg_addr == A_CMD && reg_wdata[SRST_B]));

  a_r7_exit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy) |-> (!tx_en && !rx_en && !long_frame_ok && !irq_tx && !irq_rx));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STAT && !srst_busy)
      |=> ((stat_q & $past(reg_wdata & ~cause_pulse)) == 32'h0));

  a_r4_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_busy && (cause_pulse & ST_M) != 32'h0)
      |=> ((stat_q & $past(cause_pulse & ST_M)) == $past(cause_pulse & ST_M)));

  a_r5_tx_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> ($past((cause_pulse & TX_M) != 32'h0) || $past(reg_we && reg_addr == A_IEN)));

  a_r5_rx_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> ($past((cause_pulse & RX_M) != 32'h0) || $past(reg_we && reg_addr == A_IEN)));

  a_r8_quiet_reads: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (!irq_tx && !irq_rx && !tx_en && !rx_en));
endmodule

// File: tb/mac_irq_rst_ctrl_bench.sv
module mac_irq_rst_ctrl_bench;
  localparam int AW = 4;
  localparam int NC = 16;

  logic          clk = 0, rst_n = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0, cause_pulse = '0, reg_rdata;
  logic          irq_tx, irq_rx, tx_en, rx_en, long_frame_ok, srst_busy;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mac_irq_rst_ctrl #(.AW(AW), .SRST_CYCLES(NC)) u_mac_irq_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cause_pulse(cause_pulse),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .tx_en(tx_en), .rx_en(rx_en),
    .long_frame_ok(long_frame_ok), .srst_busy(srst_busy));

  function automatic logic [31:0] rst_val(int a);
    case (a)
      3, 4: return 32'hFFFF_FFFC;
      5: return 32'h0000_0101;
      6: return 32'h0000_0800;
      7: return 32'h0000_7FFF;
      8: return 32'h0090_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pulse(logic [31:0] p);
    cause_pulse = p;
    @(posedge clk); @(negedge clk);
    cause_pulse = '0;
  endtask

  task automatic check_rst_table(string req);
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk(req, d, rst_val(a));
    end
    chk(req, {31'h0, irq_tx}, 0);
    chk(req, {31'h0, irq_rx}, 0);
  endtask

  task automatic t_reset();
    check_rst_table("R1/R10 reset table");
    chk("R7 busy idle", {31'h0, srst_busy}, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    pulse(32'hFFFF_FFFF);
    rd(2, d); chk("R2 defined causes", d, 32'h0185_0F19);
    wr(2, 32'h0000_0000);
    rd(2, d); chk("R3 zero write", d, 32'h0185_0F19);
    wr(2, 32'hFFFF_0000);
    rd(2, d); chk("R3 upper half clear", d, 32'h0000_0F19);
    wr(2, 32'h0000_0011);
    rd(2, d); chk("R3 selective clear", d, 32'h0000_0F08);
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); chk("R3 full clear", d, 32'h0);
    wr(9, 32'h1234_5678);
    rd(9, d); chk("R10 unused index", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(32'h0000_0001);
    reg_we = 1; reg_addr = 2; reg_wdata = 32'h0000_0011; cause_pulse = 32'h0000_0010;
    @(posedge clk); @(negedge clk);
    reg_we = 0; cause_pulse = '0;
    rd(2, d); chk("R4 pulse beats clear", d, 32'h0000_0010);
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R6 enable bits", d, 32'h0005_0011);
    chk("R5 idle tx", {31'h0, irq_tx}, 0);
    pulse(32'h0080_0000);
    chk("R5 unmasked-only tx", {31'h0, irq_tx}, 0);
    pulse(32'h0004_0000);
    chk("R5 tx fires", {31'h0, irq_tx}, 1);
    chk("R5 rx quiet", {31'h0, irq_rx}, 0);
    pulse(32'h0000_0008);
    chk("R5 rx masked cause", {31'h0, irq_rx}, 0);
    pulse(32'h0000_0001);
    chk("R5 rx fires", {31'h0, irq_rx}, 1);
    wr(1, 32'h0);
    chk("R5 tx masked off", {31'h0, irq_tx}, 0);
    chk("R5 rx masked off", {31'h0, irq_rx}, 0);
    wr(1, 32'h0000_0010);
    chk("R6 enable without cause", {31'h0, irq_rx}, 0);
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(0, 32'h0000_0103);
    rd(0, d); chk("R9 cmd readback", d, 32'h0000_0103);
    chk("R9 tx_en", {31'h0, tx_en}, 1);
    chk("R9 rx_en", {31'h0, rx_en}, 1);
    chk("R9 long_frame_ok", {31'h0, long_frame_ok}, 1);
    wr(0, 32'h0000_0002);
    chk("R9 tx_en off", {31'h0, tx_en}, 0);
    chk("R9 long only", {31'h0, long_frame_ok}, 1);
    wr(0, 32'h0000_0103);
    wr(3, 32'h0000_1000);
    wr(5, 32'h0000_0055);
    rd(3, d); chk("R10 tx list write", d, 32'h0000_1000);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(1, 32'h0005_0011);
    pulse(32'h0004_0010);
    wr(0, 32'h0100_0103);
    for (int i = 0; i < NC; i++) begin
      chk("R7 busy window", {31'h0, srst_busy}, 1);
      rd(i % 9, d); chk("R7 zero read", d, 32'h0);
      if (i == 3) begin
        reg_we = 1; reg_addr = 3; reg_wdata = 32'h0000_ABCD; cause_pulse = 32'hFFFF_FFFF;
      end else if (i == 5) begin
        reg_we = 1; reg_addr = 0; reg_wdata = 32'h0000_0103;
      end else if (i == NC - 1) begin
        reg_we = 1; reg_addr = 5; reg_wdata = 32'h0000_0077; cause_pulse = 32'h0000_0001;
      end
      @(posedge clk); @(negedge clk);
      reg_we = 0; cause_pulse = '0;
    end
    chk("R7 busy ends", {31'h0, srst_busy}, 0);
    chk("R9 tx_en cleared", {31'h0, tx_en}, 0);
    chk("R9 rx_en cleared", {31'h0, rx_en}, 0);
    check_rst_table("R7/R8 post soft reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_race();
    t_irq();
    t_cmd();
    t_srst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule